// File: doc/BRIEF.md
# Memory Test Access Port with Identification Word

This block is the boundary-test port of a synchronous memory. A sixteen-state controller steps on the test clock `tck` under the mode-select input `tms`. It places one serial register at a time between the serial input `tdi` and the serial output `tdo`: a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification register, or an external chain such as a boundary ring. For the external chain the block supplies a select and capture, shift and update strobes. All sampling happens on rising `tck`. `tdo` and its enable `tdo_en` are retimed on falling `tck`. An active-low asynchronous `trst_n` resets only the test logic.

The controller states are TLR (test-logic-reset), RTI (run-test/idle) and two mirrored columns. The data column is SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR and UPD_DR. The instruction column is SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR and UPD_IR. Every transition listed below is the one taken on a rising edge. In every case not listed, the controller stays in its current state.

- Leaving reset and idle: TLR goes to RTI when tms=0, and RTI goes to SEL_DR when tms=1.
- Selecting a column: SEL_DR goes to CAP_DR when tms=0 and to SEL_IR when tms=1. SEL_IR goes to CAP_IR when tms=0 and to TLR when tms=1.
- Capture and shift: CAP_x goes to SH_x when tms=0 and to EX1_x when tms=1. SH_x goes to EX1_x when tms=1.
- Exit and pause: EX1_x goes to PAU_x when tms=0 and to UPD_x when tms=1. PAU_x goes to EX2_x when tms=1. EX2_x goes back to SH_x when tms=0 and to UPD_x when tms=1.
- Update: UPD_x goes to RTI when tms=0 and to SEL_DR when tms=1.

A parameter chooses between the wide (x36) and narrow (x18) organisation, which sets the width and depth fields of the identification word.

Top module: `memtap_top`

## Requirements
- R1: `tms` and `tdi` are sampled on rising `tck`. `tdo` changes only on falling `tck`, never at a rising edge.
- R2: Driving `trst_n` low immediately puts the controller in TLR, makes IDCODE (001) the active instruction and drops `tdo_en`, without waiting for a clock.
- R3: From any state, five consecutive rising edges with tms=1 reach TLR. Every entry into TLR makes IDCODE the active instruction.
- R4: In CAP_IR the instruction shift stage loads 001, with the two low bits fixed at 01. In SH_IR it shifts toward `tdo`, least significant bit first, and `tdi` enters at the most significant bit.
- R5: A shifted instruction becomes active only on the rising edge that leaves UPD_IR. Until then the previous instruction stays in force.
- R6: With IDCODE active, CAP_DR loads the 32-bit identification word and SH_DR shifts it out bit 0 first. Its fields are: bit 0 = 1; bits 11:1 = 00000001110; bits 17:12 = 0; width field in bits 22:18; depth field in bits 27:23; bits 31:28 = 0. The width field is 00100 when wide and 00011 when narrow. The depth field is 00110 when wide and 00111 when narrow. The resulting word is 0x0310001D when wide and 0x038C001D when narrow.
- R7: When the bypass stage is selected, CAP_DR clears it to 0. In SH_DR a `tdi` bit sampled on one rising edge appears on `tdo` at the next falling edge, which is one stage of delay.
- R8: Instruction decoding selects the data register as follows: 001 selects the identification register; 000 and 010 select the external chain, and `ext_tdo` is routed to `tdo`; every other code (111 and all undefined codes) selects the bypass stage.
- R9: `ext_capture`, `ext_shift` and `ext_update` are high in CAP_DR, SH_DR and UPD_DR respectively, and only while `ext_sel` is high. At most one of them is high at a time.
- R10: `tdo_en` is high only while the controller is in SH_IR or SH_DR, as retimed at the falling edge. It is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| ext_tdo | input | 1 | Serial output of the external chain |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| ext_sel | output | 1 | External chain selected by the active instruction |
| ext_capture | output | 1 | External chain capture strobe |
| ext_shift | output | 1 | External chain shift strobe |
| ext_update | output | 1 | External chain update strobe |

## Verification
The hardest behaviour to reach from the ports is the return to TLR from each of the sixteen states. The controller state is not visible, and a return to TLR is only evident through its side effect of restoring IDCODE. The stimulus first loads BYPASS, then walks a tms path to each state in turn, applies five ones, and reads the data register. Only a real return to TLR yields the identification word instead of the bypass pattern. A second hard case is an asynchronous reset that lands mid-shift. The bench pulses `trst_n` between clock edges and checks `tdo_en` before the next edge.

// File: rtl/memtap_pkg.sv
`timescale 1ns/1ps
package memtap_pkg;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_EXTEST = 3'b000;
    localparam instr_t OP_IDCODE = 3'b001;
    localparam instr_t OP_SAMPLE = 3'b010;
    localparam instr_t OP_BYPASS = 3'b111;

    // value forced into the instruction shift stage on capture
    localparam instr_t IR_CAPTURE = instr_t'(2'b01);

    typedef enum logic [1:0] { SEL_BYP, SEL_ID, SEL_EXT } dr_sel_e;

    function automatic logic [ID_W-1:0] id_word(input bit wide);
        logic [4:0] wfield;
        logic [4:0] dfield;
        wfield = wide ? 5'b00100 : 5'b00011;
        dfield = wide ? 5'b00110 : 5'b00111;
        return {4'b0000, dfield, wfield, 6'b000000, 11'b00000001110, 1'b1};
    endfunction

endpackage

// File: rtl/memtap_fsm.sv
`timescale 1ns/1ps
module memtap_fsm
    import memtap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e state_nx
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TLR;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TLR:    state_nx = tms ? TLR    : RTI;
            RTI:    state_nx = tms ? SEL_DR : RTI;
            SEL_DR: state_nx = tms ? SEL_IR : CAP_DR;
            CAP_DR: state_nx = tms ? EX1_DR : SH_DR;
            SH_DR:  state_nx = tms ? EX1_DR : SH_DR;
            EX1_DR: state_nx = tms ? UPD_DR : PAU_DR;
            PAU_DR: state_nx = tms ? EX2_DR : PAU_DR;
            EX2_DR: state_nx = tms ? UPD_DR : SH_DR;
            UPD_DR: state_nx = tms ? SEL_DR : RTI;
            SEL_IR: state_nx = tms ? TLR    : CAP_IR;
            CAP_IR: state_nx = tms ? EX1_IR : SH_IR;
            SH_IR:  state_nx = tms ? EX1_IR : SH_IR;
            EX1_IR: state_nx = tms ? UPD_IR : PAU_IR;
            PAU_IR: state_nx = tms ? EX2_IR : PAU_IR;
            EX2_IR: state_nx = tms ? UPD_IR : SH_IR;
            UPD_IR: state_nx = tms ? SEL_DR : RTI;
        endcase
    end

endmodule

// File: rtl/memtap_ir.sv
`timescale 1ns/1ps
module memtap_ir
    import memtap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  tap_state_e state_nx,
    input  logic       tdi,
    output instr_t     ir_q,
    output logic       ir_lsb
);

    instr_t ir_sh;

    // shift stage: capture fixed pattern, shift toward tdo
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= IR_CAPTURE;
        end else if (state == CAP_IR) begin
            ir_sh <= IR_CAPTURE;
        end else if (state == SH_IR) begin
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    // parallel stage: IDCODE on any entry to reset, new code on update
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q <= OP_IDCODE;
        end else if (state_nx == TLR) begin
            ir_q <= OP_IDCODE;
        end else if (state == UPD_IR) begin
            ir_q <= ir_sh;
        end
    end

    assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/memtap_dr.sv
`timescale 1ns/1ps
module memtap_dr
    import memtap_pkg::*;
#(
    parameter bit WIDE_ORG = 1'b1
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  instr_t     ir_q,
    input  logic       tdi,
    input  logic       ext_tdo,
    output logic       dr_lsb,
    output logic       ext_sel
);

    localparam logic [ID_W-1:0] ID_VALUE = id_word(WIDE_ORG);

    dr_sel_e         sel;
    logic            byp_q;
    logic [ID_W-1:0] id_sh;

    always_comb begin
        unique case (ir_q)
            OP_IDCODE:            sel = SEL_ID;
            OP_EXTEST, OP_SAMPLE: sel = SEL_EXT;
            default:              sel = SEL_BYP;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (sel == SEL_BYP) begin
            if (state == CAP_DR)     byp_q <= 1'b0;
            else if (state == SH_DR) byp_q <= tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sh <= '0;
        end else if (sel == SEL_ID) begin
            if (state == CAP_DR)     id_sh <= ID_VALUE;
            else if (state == SH_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ID:  dr_lsb = id_sh[0];
            SEL_EXT: dr_lsb = ext_tdo;
            default: dr_lsb = byp_q;
        endcase
    end

    assign ext_sel = (sel == SEL_EXT);

endmodule

// File: rtl/memtap_top.sv
`timescale 1ns/1ps
module memtap_top
    import memtap_pkg::*;
#(
    parameter bit WIDE_ORG = 1'b1
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic ext_tdo,
    output logic tdo,
    output logic tdo_en,
    output logic ext_sel,
    output logic ext_capture,
    output logic ext_shift,
    output logic ext_update
);

    tap_state_e state;
    tap_state_e state_nx;
    instr_t     ir_q;
    logic       ir_lsb;
    logic       dr_lsb;

    memtap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state    (state),
        .state_nx (state_nx)
    );

    memtap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (state),
        .state_nx (state_nx),
        .tdi      (tdi),
        .ir_q     (ir_q),
        .ir_lsb   (ir_lsb)
    );

    memtap_dr #(.WIDE_ORG(WIDE_ORG)) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state),
        .ir_q    (ir_q),
        .tdi     (tdi),
        .ext_tdo (ext_tdo),
        .dr_lsb  (dr_lsb),
        .ext_sel (ext_sel)
    );

    // output retiming on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= (state == SH_IR) ? ir_lsb : dr_lsb;
            tdo_en <= (state == SH_IR) || (state == SH_DR);
        end
    end

    always_comb begin
        ext_capture = ext_sel && (state == CAP_DR);
        ext_shift   = ext_sel && (state == SH_DR);
        ext_update  = ext_sel && (state == UPD_DR);
    end

endmodule

// File: rtl/memtap_chk.sv
`timescale 1ns/1ps
module memtap_chk
    import memtap_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input tap_state_e state,
    input instr_t     ir_q,
    input logic       tdo_en,
    input logic       ext_sel,
    input logic       ext_capture,
    input logic       ext_shift,
    input logic       ext_update
);

    default clocking cb @(posedge tck); endclocking
    default disable iff (!trst_n);

    AST_TLR_HOLD: assert property ((state == TLR) && tms |=> (state == TLR)); // R3
    AST_TLR_IDCODE: assert property ((state == TLR) |-> (ir_q == OP_IDCODE)); // R3
    AST_IR_CHANGE_ON_UPDATE: assert property (!$stable(ir_q) |-> ($past(state) == UPD_IR) || (state == TLR)); // R5
    AST_STROBE_ONEHOT: assert property ($onehot0({ext_capture, ext_shift, ext_update})); // R9
    AST_STROBE_NEEDS_SEL: assert property ((ext_capture || ext_shift || ext_update) |-> ext_sel); // R9
    AST_TDO_EN_SHIFT_ONLY: assert property (tdo_en |-> (state == SH_IR) || (state == SH_DR)); // R10
    AST_TDO_EN_IN_SHIFT: assert property (((state == SH_DR) && $past(state) == SH_DR) |-> tdo_en); // R10

endmodule

bind memtap_top memtap_chk chk_i (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .state       (state),
    .ir_q        (ir_q),
    .tdo_en      (tdo_en),
    .ext_sel     (ext_sel),
    .ext_capture (ext_capture),
    .ext_shift   (ext_shift),
    .ext_update  (ext_update)
);

// File: tb/memtap_top_tb_top.sv
`timescale 1ns/1ps
module memtap_top_tb_top;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, ext_tdo = 1'b0;
    logic tdo, tdo_en, ext_sel, ext_capture, ext_shift, ext_update;
    logic tdo18, en18, sel18, cap18, sh18, upd18;

    int n_vec = 0;
    int n_bad = 0;

    logic s_tdo, s_en, s_tdo18, s_cap, s_sh, s_upd, s_sel;

    localparam logic [31:0] ID36 = (32'd6 << 23) | (32'd4 << 18) | (32'h00E << 1) | 32'd1;
    localparam logic [31:0] ID18 = (32'd7 << 23) | (32'd3 << 18) | (32'h00E << 1) | 32'd1;
    localparam logic [31:0] PAT  = 32'hA5C3_96E1;

    always #2.5 tck = ~tck;

    memtap_top #(.WIDE_ORG(1'b1)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .ext_tdo(ext_tdo),
        .tdo(tdo), .tdo_en(tdo_en), .ext_sel(ext_sel),
        .ext_capture(ext_capture), .ext_shift(ext_shift), .ext_update(ext_update)
    );

    memtap_top #(.WIDE_ORG(1'b0)) dut18_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .ext_tdo(ext_tdo),
        .tdo(tdo18), .tdo_en(en18), .ext_sel(sel18),
        .ext_capture(cap18), .ext_shift(sh18), .ext_update(upd18)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one rising edge with given tms/tdi, then sample after the falling edge
    task automatic step(input logic t, input logic d);
        tms = t;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
        s_tdo = tdo; s_en = tdo_en; s_tdo18 = tdo18;
        s_cap = ext_capture; s_sh = ext_shift; s_upd = ext_update; s_sel = ext_sel;
    endtask

    // from RTI to RTI, returns the captured bits seen on tdo
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output logic en_ok);
        step(1, 0); step(1, 0); step(0, 0);
        step(0, 0);       cap[0] = s_tdo; en_ok = s_en;
        step(0, code[0]); cap[1] = s_tdo; en_ok &= s_en;
        step(0, code[1]); cap[2] = s_tdo; en_ok &= s_en;
        step(1, code[2]);
        step(1, 0);
        step(0, 0);
    endtask

    // from RTI to RTI, 32-bit data register scan
    task automatic read_dr(input logic [31:0] din, output logic [31:0] dout,
                           output logic [31:0] dout18, output logic [2:0] strb,
                           output logic en_ok);
        step(1, 0);
        step(0, 0);      strb[2] = s_cap;
        step(0, din[0]); dout[0] = s_tdo; dout18[0] = s_tdo18; strb[1] = s_sh; en_ok = s_en;
        for (int i = 1; i < 32; i++) begin
            step(0, din[i]);
            dout[i] = s_tdo; dout18[i] = s_tdo18; en_ok &= s_en;
        end
        step(1, 0);
        step(1, 0);      strb[0] = s_upd;
        step(0, 0);
    endtask

    logic [7:0] pbits [16];
    int         plen  [16];

    initial begin
        logic [31:0] d36, d18;
        logic [2:0]  strb, cap;
        logic        en_ok;
        logic [31:0] exp;

        pbits[0]  = 8'b0;      plen[0]  = 0;
        pbits[1]  = 8'b1;      plen[1]  = 1;
        pbits[2]  = 8'b10;     plen[2]  = 2;
        pbits[3]  = 8'b100;    plen[3]  = 3;
        pbits[4]  = 8'b101;    plen[4]  = 3;
        pbits[5]  = 8'b1010;   plen[5]  = 4;
        pbits[6]  = 8'b10101;  plen[6]  = 5;
        pbits[7]  = 8'b1011;   plen[7]  = 4;
        pbits[8]  = 8'b11;     plen[8]  = 2;
        pbits[9]  = 8'b110;    plen[9]  = 3;
        pbits[10] = 8'b1100;   plen[10] = 4;
        pbits[11] = 8'b1101;   plen[11] = 4;
        pbits[12] = 8'b11010;  plen[12] = 5;
        pbits[13] = 8'b110101; plen[13] = 6;
        pbits[14] = 8'b11011;  plen[14] = 5;
        pbits[15] = 8'b111;    plen[15] = 3;

        // reset state
        #7;
        chk("R2 tdo_en in reset", {31'b0, tdo_en}, 32'd0);
        chk("R9 strobes in reset", {29'b0, ext_capture, ext_shift, ext_update}, 32'd0);
        @(negedge tck);
        #1;
        trst_n = 1'b1;
        step(1, 0);
        step(0, 0);
        chk("R10 tdo_en idle", {31'b0, s_en}, 32'd0);

        // identification word after reset, both organisations
        read_dr(PAT, d36, d18, strb, en_ok);
        chk("R6 id word wide", d36, ID36);
        chk("R6 id word narrow", d18, ID18);
        chk("R10 tdo_en in shift-dr", {31'b0, en_ok}, 32'd1);
        chk("R9 no strobes for idcode", {29'b0, strb}, 32'd0);

        // instruction capture pattern and bypass
        load_ir(3'b111, cap, en_ok);
        chk("R4 capture pattern", {29'b0, cap}, 32'd1);
        chk("R10 tdo_en in shift-ir", {31'b0, en_ok}, 32'd1);
        read_dr(PAT, d36, d18, strb, en_ok);
        chk("R7 bypass one-stage delay", d36, {PAT[31:1], 1'b0});

        // sweep of every instruction code
        ext_tdo = 1'b1;
        for (int c = 0; c < 8; c++) begin
            load_ir(3'(c), cap, en_ok);
            chk("R4 capture pattern sweep", {29'b0, cap}, 32'd1);
            read_dr(PAT, d36, d18, strb, en_ok);
            if (c == 1) exp = ID36;
            else if (c == 0 || c == 2) exp = 32'hFFFF_FFFF;
            else exp = {PAT[31:1], 1'b0};
            chk("R8 decode per code", d36, exp);
            chk("R9 ext strobes per code", {29'b0, strb},
                (c == 0 || c == 2) ? 32'd7 : 32'd0);
            chk("R5 code active after update", {31'b0, s_sel},
                {31'b0, (c == 0 || c == 2)});
        end
        ext_tdo = 1'b0;

        // five ones from every state restore IDCODE
        for (int k = 0; k < 16; k++) begin
            load_ir(3'b111, cap, en_ok);
            for (int b = plen[k] - 1; b >= 0; b--) step(pbits[k][b], 0);
            for (int n = 0; n < 5; n++) step(1, 0);
            step(0, 0);
            read_dr(PAT, d36, d18, strb, en_ok);
            chk($sformatf("R3 reset path from state %0d", k), d36, ID36);
        end

        // falling-edge timing of tdo, then async reset mid-shift
        load_ir(3'b111, cap, en_ok);
        step(1, 0); step(0, 0);
        step(0, 1);
        step(0, 1);
        chk("R1 tdo after falling edge", {31'b0, s_tdo}, 32'd1);
        tms = 1'b0; tdi = 1'b0;
        @(posedge tck);
        #0.5;
        chk("R1 tdo held across rising edge", {31'b0, tdo}, 32'd1);
        @(negedge tck);
        #1;
        chk("R1 tdo follows at falling edge", {31'b0, tdo}, 32'd0);
        chk("R10 tdo_en before reset", {31'b0, tdo_en}, 32'd1);
        trst_n = 1'b0;
        #0.5;
        chk("R2 async reset drops tdo_en", {31'b0, tdo_en}, 32'd0);
        #1;
        trst_n = 1'b1;
        @(negedge tck);
        #1;
        step(0, 0);
        read_dr(PAT, d36, d18, strb, en_ok);
        chk("R2 idcode after async reset", d36, ID36);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule